// File: doc/BRIEF.md
# Flash Write-Status Reporting Engine

This block stands in for the status side of a parallel NOR flash while its internal program or erase algorithm runs. A one-cycle start pulse launches either a word program (address plus data) or a sector erase (one select bit per sector). Each operation is a counted-cycle timer. When the timer expires, the block updates a small on-chip word array. Reads are strobed with an address and return registered data one cycle later.

While an operation is running, a read at any address returns a polling status byte built from the operation type and the data being programmed, not the array contents. In that byte, bit 7 is the data-polling bit, bit 6 is the toggle bit and bit 5 is the error flag. Targets in protected sectors give a short busy window and leave the array unchanged. Programming can only clear bits. A synchronous hardware-reset pulse abandons a running operation. Commands that arrive while the block is busy are dropped.

Top module: `flash_status_engine`

## Requirements
- R1: During a program operation, bit 7 of every read is the inverse of bit 7 of the data being programmed. After completion, a read at the program address returns the stored word.
- R2: During an erase operation, bit 7 of every read is 0. After completion, every word of each erased sector reads all ones.
- R3: A completed program stores the bitwise AND of the old word and the new data.
- R4: During a program, status bit 5 is 1 if the new data has a 1 where the old word has a 0, and 0 otherwise. It is 0 during an erase.
- R5: A program aimed at a protected sector (default: sector 3, addresses 12..15) keeps busy high for PROT_PROG_CYC cycles and changes nothing.
- R6: An erase whose selected sectors are all protected keeps busy high for PROT_ERASE_CYC cycles and changes nothing. Otherwise it erases only the unprotected selected sectors, over ERASE_CYC cycles. The sector of an address is its top SECT_W bits.
- R7: Program or erase starts that arrive while busy are ignored. They neither change the array nor lengthen the running operation.
- R8: A hw_reset pulse during an operation clears busy on the next clock edge and leaves the array unchanged.
- R9: The first status read of an operation returns bit 6 = 0, and each further status read inverts it, whatever the address. Status bits 4..0 read 0.
- R10: Busy rises on the edge that takes a start and stays high for exactly PROG_CYC (program) or ERASE_CYC (erase) cycles. rdy is always the inverse of busy.
- R11: After reset the array holds all ones and busy is low. Reads while idle return the array word at rd_addr, on the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_go | input | 1 | Program start pulse |
| prog_addr | input | ADDR_W | Program word address |
| prog_data | input | DATA_W | Program data |
| erase_go | input | 1 | Erase start pulse |
| erase_sel | input | NSECT | Sector select mask for erase |
| hw_reset | input | 1 | Synchronous abort of a running operation |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read result |
| rdy | output | 1 | High when no algorithm runs |
| busy | output | 1 | High while an algorithm runs |

## Verification
Programs are run with three kinds of data:
- data whose bit 7 is set and which fits the old word, so bit 7 reads 0 and there is no error;
- data that would raise cleared bits, which sets the error flag and shows that the AND rule still holds;
- clean data with bit 7 clear, which flips the polling bit the other way.

Erases are run with three sector masks: a single unprotected sector, an all-protected mask and a mixed mask. Together these separate the fake-busy length from a real erase and show which sectors are written. Status reads at two different addresses in one operation expose the toggle bit. Commands injected mid-operation, and a hardware-reset pulse, show whether the running timer or the array can be disturbed.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;

  // status byte bit positions; hosts decode these
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;
endpackage

// File: rtl/fse_timer.sv
module fse_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  logic             abort,
  output logic             active,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  assign done   = act_q && (cnt_q == '0);
  assign active = act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (abort) begin
      act_d = 1'b0;
    end else if (start) begin
      act_d = 1'b1;
      cnt_d = len - CNT_W'(1);
    end else if (done) begin
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/fse_array.sv
module fse_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_we,
  input  logic [ADDR_W-1:0]      prog_addr,
  input  logic [DATA_W-1:0]      prog_data,
  input  logic                   erase_we,
  input  logic [(1<<SECT_W)-1:0] erase_sel,
  input  logic [ADDR_W-1:0]      rd_addr_a,
  output logic [DATA_W-1:0]      rd_data_a,
  input  logic [ADDR_W-1:0]      rd_addr_b,
  output logic [DATA_W-1:0]      rd_data_b
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WPS_W = ADDR_W - SECT_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam int SEC = g >> WPS_W;
    logic hit_erase, hit_prog;
    assign hit_erase = erase_we && erase_sel[SEC];
    assign hit_prog  = prog_we && (prog_addr == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem[g] <= '1;
      else if (hit_erase) mem[g] <= '1;
      else if (hit_prog)  mem[g] <= mem[g] & prog_data;
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
  import fse_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int DATA_W         = 8,
  parameter int SECT_W         = 2,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 4'b1000,
  parameter int PROG_CYC       = 8,
  parameter int ERASE_CYC      = 20,
  parameter int PROT_PROG_CYC  = 3,
  parameter int PROT_ERASE_CYC = 12,
  parameter int CNT_W          = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_go,
  input  logic [ADDR_W-1:0]      prog_addr,
  input  logic [DATA_W-1:0]      prog_data,
  input  logic                   erase_go,
  input  logic [(1<<SECT_W)-1:0] erase_sel,
  input  logic                   hw_reset,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rdy,
  output logic                   busy
);
  localparam int NSECT = 1 << SECT_W;

  op_e               op_q, op_d;
  logic              commit_q, commit_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [DATA_W-1:0] pdata_q, pdata_d;
  logic              err_q, err_d;
  logic [NSECT-1:0]  emask_q, emask_d;
  logic              tog_q, tog_d;
  logic [DATA_W-1:0] rdq, rdd;

  logic              tmr_start, tmr_abort, tmr_done, tmr_active;
  logic [CNT_W-1:0]  tmr_len;
  logic [DATA_W-1:0] arr_rd, arr_peek, stat;
  logic              prog_we, erase_we, tgt_prot;
  logic [NSECT-1:0]  eff_sel;

  fse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .len(tmr_len),
    .abort(tmr_abort), .active(tmr_active), .done(tmr_done)
  );

  fse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_addr(paddr_q), .prog_data(pdata_q),
    .erase_we(erase_we), .erase_sel(emask_q),
    .rd_addr_a(rd_addr), .rd_data_a(arr_rd),
    .rd_addr_b(prog_addr), .rd_data_b(arr_peek)
  );

  assign tgt_prot = PROT_MASK[prog_addr[ADDR_W-1 -: SECT_W]];
  assign eff_sel  = erase_sel & ~PROT_MASK;
  assign busy     = (op_q != OP_IDLE);
  assign rdy      = ~busy;
  assign rd_data  = rdq;

  // operation launch, completion and abort
  always_comb begin
    op_d      = op_q;
    commit_d  = commit_q;
    paddr_d   = paddr_q;
    pdata_d   = pdata_q;
    err_d     = err_q;
    emask_d   = emask_q;
    tmr_start = 1'b0;
    tmr_abort = 1'b0;
    tmr_len   = '0;
    if (op_q == OP_IDLE) begin
      if (!hw_reset && prog_go) begin
        op_d      = OP_PROG;
        paddr_d   = prog_addr;
        pdata_d   = prog_data;
        commit_d  = !tgt_prot;
        err_d     = !tgt_prot && (|(~arr_peek & prog_data));
        tmr_len   = tgt_prot ? CNT_W'(PROT_PROG_CYC) : CNT_W'(PROG_CYC);
        tmr_start = 1'b1;
      end else if (!hw_reset && erase_go && (|erase_sel)) begin
        op_d      = OP_ERASE;
        emask_d   = eff_sel;
        commit_d  = |eff_sel;
        err_d     = 1'b0;
        tmr_len   = (|eff_sel) ? CNT_W'(ERASE_CYC) : CNT_W'(PROT_ERASE_CYC);
        tmr_start = 1'b1;
      end
    end else if (hw_reset) begin
      op_d      = OP_IDLE;
      tmr_abort = 1'b1;
    end else if (tmr_done) begin
      op_d = OP_IDLE;
    end
  end

  assign prog_we  = (op_q == OP_PROG)  && tmr_done && commit_q && !hw_reset;
  assign erase_we = (op_q == OP_ERASE) && tmr_done && commit_q && !hw_reset;

  // status byte and read path
  always_comb begin
    stat           = '0;
    stat[POLL_BIT] = (op_q == OP_PROG) ? ~pdata_q[POLL_BIT] : 1'b0;
    stat[TOG_BIT]  = tog_q;
    stat[ERR_BIT]  = (op_q == OP_PROG) && err_q;
    tog_d = tog_q;
    if (op_q == OP_IDLE) tog_d = 1'b0;
    else if (rd_en)      tog_d = ~tog_q;
    rdd = rdq;
    if (rd_en) rdd = busy ? stat : arr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      commit_q <= 1'b0;
      paddr_q  <= '0;
      pdata_q  <= '0;
      err_q    <= 1'b0;
      emask_q  <= '0;
      tog_q    <= 1'b0;
      rdq      <= '0;
    end else begin
      op_q     <= op_d;
      commit_q <= commit_d;
      paddr_q  <= paddr_d;
      pdata_q  <= pdata_d;
      err_q    <= err_d;
      emask_q  <= emask_d;
      tog_q    <= tog_d;
      rdq      <= rdd;
    end
  end
endmodule

// File: rtl/fse_checker.sv
module fse_checker
  import fse_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_go,
  input logic              erase_go,
  input logic              hw_reset,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              rdy,
  input op_e               op,
  input logic              pdata7,
  input logic              tmr_done
);
  p_prog_poll_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && op == OP_PROG) |=> (rd_data[POLL_BIT] == !$past(pdata7)));

  p_erase_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && op == OP_ERASE) |=> (rd_data[POLL_BIT] == 1'b0));

  p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_IDLE && !hw_reset && !tmr_done) |=> $stable(op));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hw_reset) |=> !busy);

  p_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

  p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[4:0] == '0));

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prog_go || erase_go));

  p_rdy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy != busy);
endmodule

bind flash_status_engine fse_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
  .hw_reset(hw_reset), .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
  .rdy(rdy), .op(op_q), .pdata7(pdata_q[DATA_W-1]), .tmr_done(tmr_done)
);

// File: tb/tb_flash_status_engine.sv
module tb_flash_status_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       prog_go, erase_go, hw_reset, rd_en;
  logic [3:0] prog_addr, rd_addr, erase_sel;
  logic [7:0] prog_data, rd_data;
  logic       rdy, busy;

  int total = 0;
  int bad   = 0;

  flash_status_engine dut (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_go(erase_go), .erase_sel(erase_sel),
    .hw_reset(hw_reset), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rdy(rdy), .busy(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_prog(input logic [3:0] a, input logic [7:0] d);
    prog_go = 1'b1; prog_addr = a; prog_data = d;
    @(negedge clk);
    prog_go = 1'b0;
  endtask

  task automatic start_erase(input logic [3:0] m);
    erase_go = 1'b1; erase_sel = m;
    @(negedge clk);
    erase_go = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic count_busy(inout int n);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R11 busy after reset", busy, 0);
    check("R10 rdy after reset", rdy, 1);
    rd(4'd0, d);
    check("R11 erased array after reset", d, 8'hFF);
  endtask

  task automatic t_prog_basic();
    logic [7:0] d;
    int n = 0;
    start_prog(4'd1, 8'hA5);
    count_busy(n);
    check("R10 program busy length", n, 8);
    check("R10 rdy after program", rdy, 1);
    rd(4'd1, d);
    check("R1 stored word after program", d, 8'hA5);
  endtask

  task automatic t_prog_err_poll();
    logic [7:0] d;
    int n = 0;
    start_prog(4'd1, 8'h0F);
    rd(4'd1, d);
    check("R1 R4 first status", d, 8'hA0);
    rd(4'd7, d);
    check("R9 toggled status other address", d, 8'hE0);
    count_busy(n);
    rd(4'd1, d);
    check("R3 AND of old and new", d, 8'h05);
  endtask

  task automatic t_prog_clean_poll();
    logic [7:0] d;
    int n = 0;
    start_prog(4'd2, 8'h3C);
    rd(4'd2, d);
    check("R1 R4 status without error", d, 8'h80);
    count_busy(n);
    rd(4'd2, d);
    check("R1 stored clean word", d, 8'h3C);
  endtask

  task automatic t_prog_prot();
    logic [7:0] d;
    int n = 0;
    start_prog(4'd13, 8'h00);
    count_busy(n);
    check("R5 protected program busy length", n, 3);
    rd(4'd13, d);
    check("R5 protected word unchanged", d, 8'hFF);
  endtask

  task automatic t_erase_poll();
    logic [7:0] d;
    int n = 0;
    start_prog(4'd5, 8'h11);
    count_busy(n);
    start_erase(4'b0001);
    rd(4'd0, d);
    check("R2 erase status", d, 8'h00);
    rd(4'd9, d);
    check("R9 erase toggled status", d, 8'h40);
    count_busy(n);
    rd(4'd1, d);
    check("R2 erased word addr1", d, 8'hFF);
    rd(4'd2, d);
    check("R2 erased word addr2", d, 8'hFF);
    rd(4'd5, d);
    check("R6 unselected sector untouched", d, 8'h11);
  endtask

  task automatic t_erase_prot();
    logic [7:0] d;
    int n = 0;
    start_erase(4'b1000);
    count_busy(n);
    check("R6 all-protected erase length", n, 12);
    rd(4'd5, d);
    check("R6 all-protected erase changes nothing", d, 8'h11);
    n = 0;
    start_erase(4'b1010);
    count_busy(n);
    check("R10 R6 mixed erase length", n, 20);
    rd(4'd5, d);
    check("R6 mixed erase clears unprotected", d, 8'hFF);
  endtask

  task automatic t_ignore();
    logic [7:0] d;
    int n = 0;
    start_prog(4'd8, 8'h00);
    prog_go = 1'b1; prog_addr = 4'd9; prog_data = 8'h00;
    n++;
    @(negedge clk);
    prog_go = 1'b0; erase_go = 1'b1; erase_sel = 4'b0100;
    n++;
    @(negedge clk);
    erase_go = 1'b0;
    count_busy(n);
    check("R7 busy not extended", n, 8);
    rd(4'd9, d);
    check("R7 ignored program", d, 8'hFF);
    rd(4'd8, d);
    check("R7 running program kept, ignored erase", d, 8'h00);
  endtask

  task automatic t_hw_reset();
    logic [7:0] d;
    start_prog(4'd10, 8'h00);
    @(negedge clk);
    hw_reset = 1'b1;
    @(negedge clk);
    hw_reset = 1'b0;
    check("R8 busy cleared by hw_reset", busy, 0);
    check("R8 rdy after hw_reset", rdy, 1);
    rd(4'd10, d);
    check("R8 aborted program left no data", d, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_go = 1'b0; erase_go = 1'b0; hw_reset = 1'b0;
    rd_en = 1'b0; prog_addr = '0; rd_addr = '0; erase_sel = '0; prog_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog_basic();
    t_prog_err_poll();
    t_prog_clean_poll();
    t_prog_prot();
    t_erase_poll();
    t_erase_prot();
    t_ignore();
    t_hw_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule